// File: doc/BRIEF.md
# Egress Router-Interface Check Stage

This block is the final layer-3 forwarding stage. It receives metadata for a packet whose egress router interface and destination MAC have already been resolved upstream. The metadata is the interface id, the TTL, the packet length and the cast type. The stage lowers the TTL by one and compares the length against the MTU configured for that interface. It then makes an explicit forward-or-drop decision and updates the statistics for that interface.

Each interface has an MTU and an enable bit, set through a write port. Each interface also has four saturating counters: forwarded unicast, forwarded broadcast, forwarded multicast, and dropped. A read port returns any counter, with an optional clear. Metadata enters on a valid/ready stream. Results leave one cycle later on a registered output that holds its value while the consumer stalls. Packet payload is not handled here.

Top module: `egr_rif_check`

## Requirements
- R1: For an accepted packet, `out_ttl` equals the input TTL minus one. An input TTL of 0 gives an `out_ttl` of 0. The result is valid on the cycle after acceptance.
- R2: A packet arriving with TTL 0 or 1 is dropped and increments the drop counter of its interface.
- R3: A packet whose length is greater than the interface MTU is dropped. A length equal to the MTU is forwarded.
- R4: A packet is dropped if its interface is disabled, has never been configured, or has an id at or above `N_IF`. After reset every interface is disabled. An out-of-range id updates no counter.
- R5: In `in_cast`, bit 0 marks unicast, bit 1 broadcast and bit 2 multicast. A packet with no bit set, or with more than one bit set, is dropped.
- R6: Every output beat has exactly one of `out_fwd` and `out_drop` set.
- R7: A forwarded packet increments its interface's counter for its cast type. A dropped packet increments only the drop counter. Counter select codes are 0 unicast, 1 broadcast, 2 multicast and 3 drop. All counters are zero after reset.
- R8: Counters saturate at 2^CNT_W-1 and do not wrap.
- R9: A read returns the selected counter on `rd_data`, with `rd_valid`, one cycle after `rd_en`. With `rd_clr` set, the counter becomes zero after the read. If an increment hits the same counter in the same cycle as the clear, the counter is left at 1.
- R10: `in_ready` is high when the output is empty or `out_ready` is high. A stalled output keeps its value.
- R11: A configuration write affects packets accepted on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Metadata valid |
| in_ready | output | 1 | Stage can accept metadata |
| in_rif | input | ID_W | Egress router-interface id |
| in_ttl | input | TTL_W | Incoming TTL |
| in_len | input | LEN_W | Packet length in bytes |
| in_cast | input | 3 | Cast flags: [0] unicast, [1] broadcast, [2] multicast |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_ttl | output | TTL_W | Decremented TTL |
| out_fwd | output | 1 | Forward flag |
| out_drop | output | 1 | Drop flag |
| cfg_we | input | 1 | Interface configuration write |
| cfg_rif | input | ID_W | Interface being configured |
| cfg_mtu | input | LEN_W | MTU value to store |
| cfg_en | input | 1 | Enable value to store |
| rd_en | input | 1 | Counter read request |
| rd_rif | input | ID_W | Interface to read |
| rd_sel | input | 2 | Counter select (0 ucast, 1 bcast, 2 mcast, 3 drop) |
| rd_clr | input | 1 | Clear the counter after reading |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Counter value |

## Verification
The forward/drop flags and the new TTL are registered at the clock edge that accepts the metadata. The counter update happens at that same edge. A counter read is answered one edge after `rd_en`. The bench drives every input on the falling edge and samples one falling edge later, so each result is read in the half cycle after the edge that produces it. Counter effects are checked through reads issued after the packets that caused them.

// File: rtl/egr_pkg.sv
package egr_pkg;
  typedef enum logic [1:0] {
    SEL_UCAST = 2'd0,
    SEL_BCAST = 2'd1,
    SEL_MCAST = 2'd2,
    SEL_DROP  = 2'd3
  } stat_sel_e;

  localparam int CAST_W = 3;
  localparam int SEL_W  = 2;
  localparam int NUM_STATS = 4;
endpackage

// File: rtl/egr_cfg_table.sv
module egr_cfg_table #(
  parameter int N_IF  = 800,
  parameter int ID_W  = 10,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [LEN_W-1:0] wr_mtu,
  input  logic             wr_enable,
  input  logic [ID_W-1:0]  lk_id,
  output logic             lk_hit,
  output logic [LEN_W-1:0] lk_mtu
);
  localparam logic [ID_W:0] NIF_L = (ID_W+1)'(N_IF);

  logic [LEN_W-1:0] mtu_q [N_IF];
  logic             en_q  [N_IF];
  logic             wr_ok, lk_ok;

  always_comb begin
    wr_ok  = wr_en && ({1'b0, wr_id} < NIF_L);
    lk_ok  = ({1'b0, lk_id} < NIF_L);
    lk_hit = lk_ok ? en_q[lk_id] : 1'b0;
    lk_mtu = lk_ok ? mtu_q[lk_id] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IF; i++) begin
        mtu_q[i] <= '0;
        en_q[i]  <= 1'b0;
      end
    end else if (wr_ok) begin
      mtu_q[wr_id] <= wr_mtu;
      en_q[wr_id]  <= wr_enable;
    end
  end
endmodule

// File: rtl/egr_decide.sv
module egr_decide
  import egr_pkg::*;
#(
  parameter int TTL_W = 8,
  parameter int LEN_W = 14
) (
  input  logic [TTL_W-1:0]  ttl,
  input  logic [LEN_W-1:0]  len,
  input  logic [CAST_W-1:0] cast,
  input  logic              if_ok,
  input  logic [LEN_W-1:0]  mtu,
  output logic              drop,
  output logic [TTL_W-1:0]  ttl_new,
  output stat_sel_e         sel
);
  logic ttl_dead, too_long, cast_bad;

  always_comb begin
    ttl_dead = (ttl <= TTL_W'(1));
    too_long = (len > mtu);
    cast_bad = !$onehot(cast);
    drop     = ttl_dead || too_long || cast_bad || !if_ok;
    ttl_new  = (ttl == '0) ? '0 : ttl - TTL_W'(1);
    if (drop)         sel = SEL_DROP;
    else if (cast[0]) sel = SEL_UCAST;
    else if (cast[1]) sel = SEL_BCAST;
    else              sel = SEL_MCAST;
  end
endmodule

// File: rtl/egr_stat_bank.sv
module egr_stat_bank
  import egr_pkg::*;
#(
  parameter int N_IF  = 800,
  parameter int ID_W  = 10,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [ID_W-1:0]  inc_id,
  input  stat_sel_e        inc_sel,
  input  logic             rd_en,
  input  logic [ID_W-1:0]  rd_id,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic             rd_clr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  localparam int ENT_W = NUM_STATS * CNT_W;
  localparam logic [ID_W:0] NIF_L = (ID_W+1)'(N_IF);

  logic [ENT_W-1:0] bank_q [N_IF];
  logic [ENT_W-1:0] inc_ent, clr_ent;
  logic [CNT_W-1:0] fld, rd_word, rd_data_q;
  logic             rd_ok, same, rd_valid_q;

  always_comb begin
    rd_ok   = rd_en && ({1'b0, rd_id} < NIF_L);
    same    = inc_en && rd_ok && rd_clr && (inc_id == rd_id);
    inc_ent = bank_q[inc_id];
    if (same) inc_ent[int'(rd_sel)*CNT_W +: CNT_W] = '0;
    fld = inc_ent[int'(inc_sel)*CNT_W +: CNT_W];
    if (fld != '1) inc_ent[int'(inc_sel)*CNT_W +: CNT_W] = fld + CNT_W'(1);
    clr_ent = bank_q[rd_id];
    clr_ent[int'(rd_sel)*CNT_W +: CNT_W] = '0;
    rd_word = rd_ok ? bank_q[rd_id][int'(rd_sel)*CNT_W +: CNT_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IF; i++) bank_q[i] <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (inc_en) bank_q[inc_id] <= inc_ent;
      if (rd_ok && rd_clr && !same) bank_q[rd_id] <= clr_ent;
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_word;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/egr_rif_check.sv
module egr_rif_check
  import egr_pkg::*;
#(
  parameter int N_IF  = 800,
  parameter int ID_W  = $clog2(N_IF),
  parameter int TTL_W = 8,
  parameter int LEN_W = 14,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_rif,
  input  logic [TTL_W-1:0] in_ttl,
  input  logic [LEN_W-1:0] in_len,
  input  logic [2:0]       in_cast,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TTL_W-1:0] out_ttl,
  output logic             out_fwd,
  output logic             out_drop,
  input  logic             cfg_we,
  input  logic [ID_W-1:0]  cfg_rif,
  input  logic [LEN_W-1:0] cfg_mtu,
  input  logic             cfg_en,
  input  logic             rd_en,
  input  logic [ID_W-1:0]  rd_rif,
  input  logic [1:0]       rd_sel,
  input  logic             rd_clr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [ID_W:0] NIF_L = (ID_W+1)'(N_IF);

  logic             accept, id_ok, if_hit, dec_drop;
  logic [LEN_W-1:0] if_mtu;
  logic [TTL_W-1:0] dec_ttl;
  stat_sel_e        dec_sel;

  logic             vld_q, vld_d, drop_q, drop_d;
  logic [TTL_W-1:0] ttl_q, ttl_d;

  egr_cfg_table #(.N_IF(N_IF), .ID_W(ID_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_id(cfg_rif), .wr_mtu(cfg_mtu), .wr_enable(cfg_en),
    .lk_id(in_rif), .lk_hit(if_hit), .lk_mtu(if_mtu)
  );

  egr_decide #(.TTL_W(TTL_W), .LEN_W(LEN_W)) u_dec (
    .ttl(in_ttl), .len(in_len), .cast(in_cast),
    .if_ok(if_hit), .mtu(if_mtu),
    .drop(dec_drop), .ttl_new(dec_ttl), .sel(dec_sel)
  );

  egr_stat_bank #(.N_IF(N_IF), .ID_W(ID_W), .CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .inc_en(accept && id_ok), .inc_id(in_rif), .inc_sel(dec_sel),
    .rd_en(rd_en), .rd_id(rd_rif), .rd_sel(rd_sel), .rd_clr(rd_clr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_comb begin
    in_ready = !vld_q || out_ready;
    accept   = in_valid && in_ready;
    id_ok    = ({1'b0, in_rif} < NIF_L);
    vld_d    = vld_q;
    ttl_d    = ttl_q;
    drop_d   = drop_q;
    if (accept) begin
      vld_d  = 1'b1;
      ttl_d  = dec_ttl;
      drop_d = dec_drop;
    end else if (out_ready) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ttl_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      ttl_q  <= ttl_d;
      drop_q <= drop_d;
    end
  end

  assign out_valid = vld_q;
  assign out_ttl   = ttl_q;
  assign out_drop  = drop_q;
  assign out_fwd   = !drop_q;

  p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fwd != out_drop));

  p_ttl_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_ttl > TTL_W'(1)) |=> (out_ttl == $past(in_ttl) - TTL_W'(1)));

  p_cast_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !$onehot(in_cast)) |=> out_drop);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ttl) && $stable(out_drop)));
endmodule

// File: tb/egr_rif_check_bench.sv
module egr_rif_check_bench;
  localparam int N_IF = 800;
  localparam int ID_W = 10;
  localparam int CNT_W = 4;

  logic clk, rst_n;
  logic in_valid, in_ready, out_valid, out_ready, out_fwd, out_drop;
  logic [ID_W-1:0] in_rif, cfg_rif, rd_rif;
  logic [7:0] in_ttl, out_ttl;
  logic [13:0] in_len, cfg_mtu;
  logic [2:0] in_cast;
  logic cfg_we, cfg_en, rd_en, rd_clr, rd_valid;
  logic [1:0] rd_sel;
  logic [CNT_W-1:0] rd_data;
  int checks = 0, errors = 0;

  egr_rif_check #(.N_IF(N_IF), .ID_W(ID_W), .CNT_W(CNT_W)) u_egr_rif_check (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: rif[43:34] ttl[33:26] len[25:12] cast[11:9] fwd[8] ttl_out[7:0]
  localparam int NV = 13;
  localparam logic [43:0] VEC [NV] = '{
    {10'd3,   8'd64,  14'd100,  3'b001, 1'b1, 8'd63},
    {10'd3,   8'd1,   14'd100,  3'b001, 1'b0, 8'd0},
    {10'd3,   8'd0,   14'd100,  3'b001, 1'b0, 8'd0},
    {10'd3,   8'd2,   14'd1500, 3'b010, 1'b1, 8'd1},
    {10'd3,   8'd9,   14'd1501, 3'b100, 1'b0, 8'd8},
    {10'd5,   8'd9,   14'd64,   3'b100, 1'b1, 8'd8},
    {10'd5,   8'd9,   14'd65,   3'b001, 1'b0, 8'd8},
    {10'd7,   8'd9,   14'd10,   3'b001, 1'b0, 8'd8},
    {10'd9,   8'd9,   14'd10,   3'b001, 1'b0, 8'd8},
    {10'd3,   8'd9,   14'd10,   3'b000, 1'b0, 8'd8},
    {10'd3,   8'd9,   14'd10,   3'b011, 1'b0, 8'd8},
    {10'd900, 8'd9,   14'd10,   3'b001, 1'b0, 8'd8},
    {10'd3,   8'd255, 14'd0,    3'b001, 1'b1, 8'd254}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int id, input int mtu, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rif = ID_W'(id); cfg_mtu = 14'(mtu); cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive at falling edge, accepted at next rising edge, leaves at the falling edge after
  task automatic send(input int id, input int ttl, input int len, input logic [2:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_rif = ID_W'(id); in_ttl = 8'(ttl); in_len = 14'(len); in_cast = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd(input int id, input int sel, input logic clr, output logic [CNT_W-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_rif = ID_W'(id); rd_sel = 2'(sel); rd_clr = clr;
    @(negedge clk);
    rd_en = 1'b0; rd_clr = 1'b0;
    v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] v;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; cfg_we = 1'b0; rd_en = 1'b0; rd_clr = 1'b0;
    in_rif = '0; in_ttl = '0; in_len = '0; in_cast = '0;
    cfg_rif = '0; cfg_mtu = '0; cfg_en = 1'b0; rd_rif = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R10 reset in_ready", 32'(in_ready), 1);
    chk("R6 reset out_valid", 32'(out_valid), 0);
    rd(3, 0, 1'b0, v); chk("R7 reset counter", 32'(v), 0);
    chk("R9 rd_valid", 32'(rd_valid), 1);
    send(3, 9, 10, 3'b001);
    chk("R4 disabled after reset", 32'(out_drop), 1);
    rd(3, 3, 1'b1, v); chk("R4 drop counted", 32'(v), 1);

    cfg(3, 1500, 1'b1); cfg(5, 64, 1'b1); cfg(7, 1500, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] e;
      e = VEC[i];
      send(int'(e[43:34]), int'(e[33:26]), int'(e[25:12]), e[11:9]);
      chk($sformatf("R1 vec%0d valid", i), 32'(out_valid), 1);
      chk($sformatf("R2 R3 R4 R5 vec%0d fwd", i), 32'(out_fwd), 32'(e[8]));
      chk($sformatf("R6 vec%0d drop", i), 32'(out_drop), 32'(!e[8]));
      chk($sformatf("R1 vec%0d ttl", i), 32'(out_ttl), 32'(e[7:0]));
    end
    @(negedge clk);
    chk("R10 out_valid drains", 32'(out_valid), 0);

    rd(3, 0, 1'b0, v); chk("R7 if3 ucast", 32'(v), 2);
    rd(3, 1, 1'b0, v); chk("R7 if3 bcast", 32'(v), 1);
    rd(3, 2, 1'b0, v); chk("R7 if3 mcast", 32'(v), 0);
    rd(3, 3, 1'b0, v); chk("R2 if3 drop", 32'(v), 5);
    rd(5, 2, 1'b0, v); chk("R7 if5 mcast", 32'(v), 1);
    rd(5, 3, 1'b0, v); chk("R3 if5 drop", 32'(v), 1);
    rd(7, 3, 1'b0, v); chk("R4 if7 drop", 32'(v), 1);
    rd(9, 3, 1'b0, v); chk("R4 if9 drop", 32'(v), 1);

    cfg(9, 100, 1'b1);
    send(9, 9, 100, 3'b010);
    chk("R11 new config used", 32'(out_fwd), 1);

    for (int i = 0; i < 20; i++) send(5, 9, 10, 3'b001);
    rd(5, 0, 1'b0, v); chk("R8 saturate", 32'(v), 15);
    rd(5, 0, 1'b1, v); chk("R9 clear returns old", 32'(v), 15);
    rd(5, 0, 1'b0, v); chk("R9 cleared", 32'(v), 0);

    @(negedge clk);
    in_valid = 1'b1; in_rif = 10'd5; in_ttl = 8'd9; in_len = 14'd10; in_cast = 3'b001;
    rd_en = 1'b1; rd_rif = 10'd5; rd_sel = 2'd0; rd_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rd_en = 1'b0; rd_clr = 1'b0;
    chk("R9 coincident read old", 32'(rd_data), 0);
    rd(5, 0, 1'b0, v); chk("R9 coincident leaves 1", 32'(v), 1);

    out_ready = 1'b0;
    send(3, 20, 10, 3'b001);
    chk("R10 stalled in_ready", 32'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b1; in_rif = 10'd3; in_ttl = 8'd40; in_len = 14'd10; in_cast = 3'b001;
    @(negedge clk);
    chk("R10 held ttl", 32'(out_ttl), 19);
    chk("R10 held valid", 32'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next beat ttl", 32'(out_ttl), 39);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule